// File: doc/BRIEF.md
# Field Memory Playback Output Sequencer

This block moves pixels out of a playback FIFO onto a video output port whose consumer is an external field memory. It has no raster timing generator. The only timing reference is an incoming vertical sync. Each rising edge of that sync starts a new field. On that edge the block raises a one-clock reset toward the field memory, so that the memory's write pointer returns to its start before the first pixel of the new field arrives.

The block never drops a pixel. A pixel leaves the FIFO only when the FIFO holds data, and every pixel taken is written exactly once, marked by a write-enable qualifier. When the FIFO runs dry, the output simply waits, so the effective pixel rate follows bus load. A toggle that advances on the line-locked clock enable caps the rate at one pixel per two enabled cycles. A saturating counter reports how many pixels have been written in the current field, so a testbench can check the field's length.

Top module: `fmpb_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fifo_pop_o`, `pix_we_o`, `fmem_rst_o`, `pix_o` and `field_count_o` are all zero.
- R2: No pixel is popped until a rising edge of `vsync_i` has been seen after reset.
- R3: `fmem_rst_o` is high for exactly one cycle, in the cycle after a sampled rising edge of `vsync_i` (sync high, and low in the previous cycle). Holding sync high produces no further pulse.
- R4: No pop occurs in the cycle in which the sync rising edge is sampled, so `pix_we_o` is low whenever `fmem_rst_o` is high, and the first pixel of a field follows the memory reset.
- R5: `fifo_pop_o` is high only when `llc_en_i` is high, `fifo_empty_i` is low and the block has been armed by a sync edge.
- R6: A toggle advances on each cycle where `llc_en_i` is high. It is 0 after reset, and a pop is allowed only while it is 1, so consecutive pops are separated by at least two enabled cycles.
- R7: Each pop is followed, in the next cycle, by `pix_we_o` high for one cycle, with `pix_o` equal to the `fifo_data_i` value present at the pop.
- R8: In a cycle after one with no pop, `pix_we_o` is low and `pix_o` keeps its previous value.
- R9: `field_count_o` reads 0 in the cycle `fmem_rst_o` is high. It rises by one with each `pix_we_o` of the field and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| llc_en_i | input | 1 | Clock enable qualifying pixel slots |
| vsync_i | input | 1 | Vertical sync, field timing reference |
| fifo_empty_i | input | 1 | Playback FIFO holds no data |
| fifo_data_i | input | PIX_W | Head-of-FIFO pixel (show-ahead) |
| fifo_pop_o | output | 1 | Take the head pixel this cycle |
| pix_o | output | PIX_W | Pixel toward the field memory |
| pix_we_o | output | 1 | Write-enable qualifier for pix_o |
| fmem_rst_o | output | 1 | One-clock field memory reset |
| field_count_o | output | CNT_W | Pixels written in the current field |

## Verification
The hardest case to reach is the interaction at a field boundary. A pop slot, data available, and a sync rising edge can all fall in the same cycle, and that is also where the counter clears and where it has to reach saturation. The bench gets there with a pseudo-random sweep of the enable, empty and sync inputs over many fields of differing lengths, with a narrow counter so that saturation happens often. A reference model in the bench predicts every output in every cycle. A separate check counts enabled cycles between pops.

// File: rtl/fmpb_pkg.sv
package fmpb_pkg;

  typedef enum logic {
    SLOT_WAIT = 1'b0,
    SLOT_OPEN = 1'b1
  } slot_e;

endpackage

// File: rtl/fmpb_vs_edge.sv
module fmpb_vs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic rise_o,
  output logic armed_o,
  output logic fmem_rst_o
);

  logic vs_q, vs_d;
  logic armed_q, armed_d;
  logic frst_q, frst_d;

  always_comb begin
    rise_o  = vsync_i & ~vs_q;
    vs_d    = vsync_i;
    armed_d = armed_q | rise_o;
    frst_d  = rise_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      armed_q <= 1'b0;
      frst_q  <= 1'b0;
    end else begin
      vs_q    <= vs_d;
      armed_q <= armed_d;
      frst_q  <= frst_d;
    end
  end

  assign armed_o    = armed_q;
  assign fmem_rst_o = frst_q;

  AST_FRST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmem_rst_o |=> !fmem_rst_o); // R3

endmodule

// File: rtl/fmpb_pace.sv
module fmpb_pace
  import fmpb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic slot_o
);

  slot_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (en_i) begin
      ph_d = (ph_q == SLOT_OPEN) ? SLOT_WAIT : SLOT_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= SLOT_WAIT;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign slot_o = en_i & (ph_q == SLOT_OPEN);

endmodule

// File: rtl/fmpb_field_cnt.sv
module fmpb_field_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R9

endmodule

// File: rtl/fmpb_seq.sv
module fmpb_seq #(
  parameter int unsigned PIX_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             llc_en_i,
  input  logic             vsync_i,
  input  logic             fifo_empty_i,
  input  logic [PIX_W-1:0] fifo_data_i,
  output logic             fifo_pop_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_we_o,
  output logic             fmem_rst_o,
  output logic [CNT_W-1:0] field_count_o
);

  // reset: asserted asynchronously, released through a synchronizer chain
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  logic vs_rise, armed, slot;

  fmpb_vs_edge u_vs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .vsync_i    (vsync_i),
    .rise_o     (vs_rise),
    .armed_o    (armed),
    .fmem_rst_o (fmem_rst_o)
  );

  fmpb_pace u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (llc_en_i),
    .slot_o (slot)
  );

  logic pop;
  assign pop        = slot & armed & ~fifo_empty_i & ~vs_rise;
  assign fifo_pop_o = pop;

  fmpb_field_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (vs_rise),
    .inc_i  (pop),
    .cnt_o  (field_count_o)
  );

  // output pixel register, loaded only on a pop
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             we_q, we_d;

  always_comb begin
    pix_d = pix_q;
    we_d  = pop;
    if (pop) begin
      pix_d = fifo_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      we_q  <= 1'b0;
    end else begin
      pix_q <= pix_d;
      we_q  <= we_d;
    end
  end

  assign pix_o    = pix_q;
  assign pix_we_o = we_q;

  AST_POP_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_pop_o |-> (llc_en_i && !fifo_empty_i)); // R5
  AST_POP_SPACED: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_pop_o |=> !fifo_pop_o); // R6
  AST_WE_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_pop_o |=> (pix_we_o && pix_o == $past(fifo_data_i))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fifo_pop_o |=> (!pix_we_o && $stable(pix_o))); // R8
  AST_FRST_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_n)
    fmem_rst_o |-> !pix_we_o); // R4
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n)
    fmem_rst_o |-> field_count_o == '0); // R9

endmodule

// File: tb/fmpb_seq_tb.sv
module fmpb_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en, vs, empty;
  logic [PIX_W-1:0] data;
  logic             pop, we, frst;
  logic [PIX_W-1:0] pix;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int errors = 0;

  // reference state
  int   m_ph, m_armed, m_vsp, m_we, m_rst, m_cnt, m_pix;
  int   en_since_pop;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmpb_seq #(.PIX_W(PIX_W), .CNT_W(CNT_W)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .llc_en_i      (en),
    .vsync_i       (vs),
    .fifo_empty_i  (empty),
    .fifo_data_i   (data),
    .fifo_pop_o    (pop),
    .pix_o         (pix),
    .pix_we_o      (we),
    .fmem_rst_o    (frst),
    .field_count_o (cnt)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // one cycle: check registered outputs, drive, check pop, advance model
  task automatic step(input logic e, input logic v, input logic mt);
    int rise, xpop;
    @(negedge clk);
    chk(int'(we),   m_we,  "R7/R8 we");
    chk(int'(frst), m_rst, "R3 fmem_rst");
    chk(int'(pix),  m_pix, "R7/R8 pix");
    chk(int'(cnt),  m_cnt, "R9 count");
    if (frst) chk(int'(we), 0, "R4 we during fmem_rst");
    lfsr = nxt(lfsr);
    en = e; vs = v; empty = mt; data = lfsr[PIX_W-1:0];
    #1;
    rise = (v && !m_vsp) ? 1 : 0;
    xpop = (e && m_ph == 1 && !mt && m_armed == 1 && rise == 0) ? 1 : 0;
    chk(int'(pop), xpop, (m_armed == 1) ? "R5 pop" : "R2 pop before sync");
    if (rise == 1) chk(int'(pop), 0, "R4 pop on sync edge");
    if (pop) begin
      chk(int'(en_since_pop >= 2), 1, "R6 pop spacing");
      en_since_pop = 0;
    end
    if (e) en_since_pop++;
    if (e) m_ph = 1 - m_ph;
    if (rise == 1) m_armed = 1;
    m_vsp = v;
    m_rst = rise;
    m_we  = xpop;
    if (xpop == 1) m_pix = data;
    if (rise == 1) m_cnt = 0;
    else if (xpop == 1 && m_cnt != CMAX) m_cnt++;
  endtask

  initial begin
    m_ph = 0; m_armed = 0; m_vsp = 0; m_we = 0; m_rst = 0; m_cnt = 0; m_pix = 0;
    en_since_pop = 2;
    rst_n = 1'b0; en = 1'b0; vs = 1'b0; empty = 1'b1; data = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(int'(pop), 0, "R1 pop");   chk(int'(we), 0, "R1 we");
    chk(int'(frst), 0, "R1 fmem_rst"); chk(int'(pix), 0, "R1 pix");
    chk(int'(cnt), 0, "R1 count");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // synchronizer release, inputs idle
    // R2: data available, no sync yet
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0);
    // fields: mode 0 max rate, 1 random empty, 2 random enable, 3 both random
    for (int f = 0; f < 48; f++) begin
      int len, mode, vlen;
      mode = f % 4;
      len  = 10 + (f * 7) % 60;
      vlen = 1 + f % 4;
      for (int i = 0; i < len; i++) begin
        logic e, mt, v;
        v  = (i < vlen);
        e  = (mode == 0 || mode == 1) ? 1'b1 : lfsr[3];
        mt = (mode == 0 || mode == 2) ? 1'b0 : (lfsr[5] & lfsr[7]);
        if (f % 5 == 4) e = 1'b1;          // sync edge may meet an open slot
        step(e, v, mt);
      end
    end
    // R3: sync held high over many cycles gives one pulse only
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule